// File: doc/BRIEF.md
# Debug Exception Arbiter

This block sits beside the retire stage of a processor pipeline and decides, for each retiring instruction, whether a debug exception is entered. Four kinds of request can arrive with a retirement: a software breakpoint instruction (wide or narrow encoding), a hit from one of a set of programmable instruction-address comparators, a data-watchpoint hit carrying the number of the watchpoint slot that matched, and an instruction-count trap. When at least one request is present and the current interrupt level is below the fixed debug level of 6, the block records which single source is reported, saves the retiring address, loads the status value that software sees on entry, and pulses a redirect strobe toward the fetch unit.

When the current interrupt level is already 6 or more, every request is dropped without trace. The instruction-address comparators are programmed through a small register write port: one address slot per comparator and one enable slot that holds an enable bit per comparator. The block does not fetch from the debug vector. It only signals the redirect.

Top module: `dbg_exc_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `redirect` is 0 and `cause`, `epc` and `status` are all 0.
- R2: A request is taken only when `retire_valid` is 1 and `cur_level` is below 6. A request at level 6 or above, or with `retire_valid` at 0, leaves `redirect` at 0 and `cause`, `epc` and `status` unchanged.
- R3: The cause value is one-hot in its low five bits: instruction count = 0x1, instruction-address comparator = 0x2, data watchpoint = 0x4, wide break instruction = 0x8, narrow break instruction = 0x10.
- R4: For a data watchpoint, `dbrk_idx` is placed in `cause` starting at bit 8. For example, slot 1 gives 0x104.
- R5: On entry, `status` becomes 0x16. This is bit 4 (exception mode) ORed with level 6 in bits 3:0.
- R6: On entry, `epc` takes the `retire_pc` of the instruction that caused the entry.
- R7: Comparator k fires only when its enable bit (bit k of the enable slot) is 1 and `retire_pc` equals its address slot exactly. A cleared enable bit or a differing address produces no entry.
- R8: When several sources request together, only one is reported. The order is instruction-address comparator, then instruction count, then wide break, then narrow break, then data watchpoint. A comparator match therefore outranks a break instruction at the same address.
- R9: `redirect` rises in the cycle after the triggering retirement and lasts exactly one cycle. A retirement presented in the redirect cycle is discarded.
- R10: Each entry overwrites `cause` completely. No bit from an earlier entry survives.
- R11: A write with `cfg_we` at 1 stores `cfg_wdata` into address slot k when `cfg_addr` = k (k < NUM_IBRK). When `cfg_addr` = NUM_IBRK, the low NUM_IBRK bits of `cfg_wdata` go into the enable slot. The new value applies to retirements from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | AW | Address of the retiring instruction |
| cur_level | input | 4 | Current interrupt level |
| brk_wide | input | 1 | Retiring instruction is the wide break |
| brk_narrow | input | 1 | Retiring instruction is the narrow break |
| icount_trap | input | 1 | Instruction-count trap request |
| dbrk_hit | input | 1 | Data watchpoint matched |
| dbrk_idx | input | DIW | Number of the matching watchpoint slot |
| cfg_we | input | 1 | Comparator register write strobe |
| cfg_addr | input | CFGW | Comparator register select |
| cfg_wdata | input | AW | Comparator register write data |
| redirect | output | 1 | One-cycle strobe to enter the debug vector |
| cause | output | 32 | Recorded cause |
| epc | output | AW | Saved address of the triggering instruction |
| status | output | 5 | Status on entry: exception-mode bit and level |

## Verification
The case that is hardest to reach from the ports is an instruction-address match that lands on the same retirement as a break instruction, an instruction-count trap and a watchpoint hit. Each comparator must be programmed through the write port, and its enable must be set in an earlier cycle, before that retirement is presented. The vector table does this for every row: it writes the address slot, then the enable slot, and only then drives the retirement. Rows with the enable cleared, with an address one word off, and with the level at 6 show that a programmed comparator does not fire when it should not. A directed run holds a break request for three cycles to show that the retirement in the redirect cycle is discarded.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

  localparam int DBG_LEVEL = 6;
  localparam int LVLW      = 4;
  localparam int CAUSE_W   = 32;
  localparam int STAT_W    = 5;
  localparam int IDX_LSB   = 8;

  // One-hot cause bit positions
  localparam int CB_ICOUNT = 0;
  localparam int CB_IADDR  = 1;
  localparam int CB_DATA   = 2;
  localparam int CB_WIDE   = 3;
  localparam int CB_NARROW = 4;
  localparam int EXCM_BIT  = 4;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_IADDR  = 3'd1,
    SRC_ICOUNT = 3'd2,
    SRC_WIDE   = 3'd3,
    SRC_NARROW = 3'd4,
    SRC_DATA   = 3'd5
  } src_e;

  // Cause word for a selected source; idx only matters for data watchpoints
  function automatic logic [CAUSE_W-1:0] cause_of(input src_e s, input logic [7:0] idx);
    logic [CAUSE_W-1:0] w;
    w = '0;
    case (s)
      SRC_ICOUNT: w[CB_ICOUNT] = 1'b1;
      SRC_IADDR:  w[CB_IADDR]  = 1'b1;
      SRC_WIDE:   w[CB_WIDE]   = 1'b1;
      SRC_NARROW: w[CB_NARROW] = 1'b1;
      SRC_DATA: begin
        w[CB_DATA] = 1'b1;
        w[IDX_LSB +: 8] = idx;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] status_on_entry();
    logic [STAT_W-1:0] s;
    s = STAT_W'(DBG_LEVEL);
    s[EXCM_BIT] = 1'b1;
    return s;
  endfunction

  function automatic logic level_permits(input logic [LVLW-1:0] lvl);
    return (lvl < LVLW'(DBG_LEVEL));
  endfunction

endpackage

// File: rtl/dbg_ibrk_unit.sv
module dbg_ibrk_unit #(
  parameter int NUM_IBRK = 2,
  parameter int AW       = 32,
  parameter int CFGW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CFGW-1:0] cfg_addr,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            pc_valid,
  input  logic [AW-1:0]   pc,
  output logic            hit_any
);

  localparam logic [CFGW-1:0] EN_SLOT = CFGW'(NUM_IBRK);

  logic [NUM_IBRK-1:0] en_q;
  logic [NUM_IBRK-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (cfg_we && (cfg_addr == EN_SLOT))
      en_q <= cfg_wdata[NUM_IBRK-1:0];
  end

  for (genvar k = 0; k < NUM_IBRK; k++) begin : g_cmp
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_q <= '0;
      else if (cfg_we && (cfg_addr == CFGW'(k)))
        addr_q <= cfg_wdata;
    end

    assign hit_vec[k] = pc_valid & en_q[k] & (addr_q == pc);
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/dbg_prio_sel.sv
module dbg_prio_sel
  import dbg_arb_pkg::*;
#(
  parameter int DIW = 1
) (
  input  logic               iaddr_hit,
  input  logic               icount_req,
  input  logic               wide_req,
  input  logic               narrow_req,
  input  logic               data_req,
  input  logic [DIW-1:0]     data_idx,
  output logic               req_any,
  output logic [CAUSE_W-1:0] cause_word
);

  src_e sel;

  // Fixed order: comparator, count, wide, narrow, watchpoint
  always_comb begin
    if (iaddr_hit)       sel = SRC_IADDR;
    else if (icount_req) sel = SRC_ICOUNT;
    else if (wide_req)   sel = SRC_WIDE;
    else if (narrow_req) sel = SRC_NARROW;
    else if (data_req)   sel = SRC_DATA;
    else                 sel = SRC_NONE;
  end

  assign req_any    = (sel != SRC_NONE);
  assign cause_word = cause_of(sel, 8'(data_idx));

endmodule

// File: rtl/dbg_entry_regs.sv
module dbg_entry_regs
  import dbg_arb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_valid,
  input  logic [LVLW-1:0]    cur_level,
  input  logic               req_any,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [AW-1:0]      pc,
  output logic               take,
  output logic               redirect_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [AW-1:0]      epc_q,
  output logic [STAT_W-1:0]  status_q
);

  logic lvl_ok;

  assign lvl_ok = level_permits(cur_level);
  // A retirement in the redirect cycle lies on the flushed path
  assign take   = retire_valid & req_any & lvl_ok & ~redirect_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      cause_q    <= '0;
      epc_q      <= '0;
      status_q   <= '0;
    end else begin
      redirect_q <= take;
      if (take) begin
        cause_q  <= cause_in;
        epc_q    <= pc;
        status_q <= status_on_entry();
      end
    end
  end

endmodule

// File: rtl/dbg_exc_arbiter.sv
module dbg_exc_arbiter
  import dbg_arb_pkg::*;
#(
  parameter int NUM_IBRK = 2,
  parameter int NUM_DBRK = 2,
  parameter int AW       = 32,
  parameter int DIW      = (NUM_DBRK > 1) ? $clog2(NUM_DBRK) : 1,
  parameter int CFGW     = $clog2(NUM_IBRK + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_valid,
  input  logic [AW-1:0]      retire_pc,
  input  logic [LVLW-1:0]    cur_level,
  input  logic               brk_wide,
  input  logic               brk_narrow,
  input  logic               icount_trap,
  input  logic               dbrk_hit,
  input  logic [DIW-1:0]     dbrk_idx,
  input  logic               cfg_we,
  input  logic [CFGW-1:0]    cfg_addr,
  input  logic [AW-1:0]      cfg_wdata,
  output logic               redirect,
  output logic [CAUSE_W-1:0] cause,
  output logic [AW-1:0]      epc,
  output logic [STAT_W-1:0]  status
);

  // Named internal events for the checker
  logic               ibrk_hit;
  logic               sel_req;
  logic [CAUSE_W-1:0] sel_cause;
  logic               take_evt;

  dbg_ibrk_unit #(.NUM_IBRK(NUM_IBRK), .AW(AW), .CFGW(CFGW)) u_ibrk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pc_valid  (retire_valid),
    .pc        (retire_pc),
    .hit_any   (ibrk_hit)
  );

  dbg_prio_sel #(.DIW(DIW)) u_sel (
    .iaddr_hit  (ibrk_hit),
    .icount_req (icount_trap),
    .wide_req   (brk_wide),
    .narrow_req (brk_narrow),
    .data_req   (dbrk_hit),
    .data_idx   (dbrk_idx),
    .req_any    (sel_req),
    .cause_word (sel_cause)
  );

  dbg_entry_regs #(.AW(AW)) u_entry (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_valid (retire_valid),
    .cur_level    (cur_level),
    .req_any      (sel_req),
    .cause_in     (sel_cause),
    .pc           (retire_pc),
    .take         (take_evt),
    .redirect_q   (redirect),
    .cause_q      (cause),
    .epc_q        (epc),
    .status_q     (status)
  );

endmodule

// File: rtl/dbg_arb_checker.sv
module dbg_arb_checker #(
  parameter int AW       = 32,
  parameter int NUM_DBRK = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire_valid,
  input logic [AW-1:0] retire_pc,
  input logic [3:0]    cur_level,
  input logic          redirect,
  input logic [31:0]   cause,
  input logic [AW-1:0] epc,
  input logic [4:0]    status,
  input logic          take_evt,
  input logic          ibrk_hit
);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && cur_level >= 4'd6) |=> !redirect);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ($countones(cause[4:0]) == 1));

  p_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cause[2]) |-> (cause[31:8] < 24'(NUM_DBRK)));

  p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (status == 5'h16));

  p_epc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> (epc == $past(retire_pc)));

  p_iaddr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && ibrk_hit) |=> (cause == 32'h2));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> ($stable(cause) && $stable(epc) && $stable(status)));

endmodule

bind dbg_exc_arbiter dbg_arb_checker #(.AW(AW), .NUM_DBRK(NUM_DBRK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_valid (retire_valid),
  .retire_pc    (retire_pc),
  .cur_level    (cur_level),
  .redirect     (redirect),
  .cause        (cause),
  .epc          (epc),
  .status       (status),
  .take_evt     (take_evt),
  .ibrk_hit     (ibrk_hit)
);

// File: tb/dbg_exc_arbiter_test.sv
module dbg_exc_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_valid = 1'b0;
  logic [31:0] retire_pc = '0;
  logic [3:0]  cur_level = '0;
  logic        brk_wide = 1'b0, brk_narrow = 1'b0, icount_trap = 1'b0, dbrk_hit = 1'b0;
  logic [0:0]  dbrk_idx = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        redirect;
  logic [31:0] cause, epc;
  logic [4:0]  status;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_exc_arbiter uut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .cur_level(cur_level), .brk_wide(brk_wide), .brk_narrow(brk_narrow),
    .icount_trap(icount_trap), .dbrk_hit(dbrk_hit), .dbrk_idx(dbrk_idx),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .redirect(redirect), .cause(cause), .epc(epc), .status(status)
  );

  typedef struct packed {
    logic        valid;
    logic [3:0]  lvl;
    logic        wide;
    logic        narrow;
    logic        icnt;
    logic        dbrk;
    logic        didx;
    logic        ien;
    logic [31:0] iaddr;
    logic [31:0] pc;
    logic        take;
    logic [31:0] cause;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1,4'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1000,1'b1,32'h8},
    '{1'b1,4'd6,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1004,1'b0,32'h0},
    '{1'b1,4'd5,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1010,1'b1,32'h10},
    '{1'b1,4'd7,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1014,1'b0,32'h0},
    '{1'b1,4'd5,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,   32'h1020,1'b1,32'h1},
    '{1'b1,4'd6,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,   32'h1024,1'b0,32'h0},
    '{1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h1030,32'h1030,1'b1,32'h2},
    '{1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h1040,32'h1040,1'b0,32'h0},
    '{1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h1050,32'h1054,1'b0,32'h0},
    '{1'b1,4'd5,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,   32'h1060,1'b1,32'h104},
    '{1'b1,4'd6,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,   32'h1064,1'b0,32'h0},
    '{1'b1,4'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,32'h1070,32'h1070,1'b1,32'h2},
    '{1'b1,4'd5,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,   32'h1080,1'b1,32'h1},
    '{1'b1,4'd5,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,   32'h1090,1'b1,32'h8},
    '{1'b1,4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,   32'h10a0,1'b1,32'h4},
    '{1'b1,4'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h10b0,32'h10b0,1'b1,32'h8},
    '{1'b1,4'd5,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,32'h0,   32'h10c0,1'b1,32'h10},
    '{1'b0,4'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h10d0,1'b0,32'h0},
    '{1'b1,4'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h10e0,32'h10e0,1'b0,32'h0}
  };
  localparam string TAGS [NV] = '{"R3","R2","R3","R2","R3","R2","R7","R7","R7","R4",
                                  "R2","R8","R8","R8","R10","R8","R8","R2","R2"};

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_retire();
    retire_valid = 1'b0; brk_wide = 1'b0; brk_narrow = 1'b0;
    icount_trap = 1'b0; dbrk_hit = 1'b0; dbrk_idx = '0;
  endtask

  logic [31:0] exp_cause = '0, exp_epc = '0;
  logic [4:0]  exp_stat = '0;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "redirect", {31'b0, redirect}, 32'h0);
    check("R1", "cause", cause, 32'h0);
    check("R1", "epc", epc, 32'h0);
    check("R1", "status", {27'b0, status}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "redirect after release", {31'b0, redirect}, 32'h0);

    // Table walk: program comparator 0, then retire one instruction
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cfg_write(2'd0, v.iaddr);
      cfg_write(2'd2, {31'b0, v.ien});
      retire_valid = v.valid; cur_level = v.lvl; retire_pc = v.pc;
      brk_wide = v.wide; brk_narrow = v.narrow; icount_trap = v.icnt;
      dbrk_hit = v.dbrk; dbrk_idx = v.didx;
      @(negedge clk);
      clear_retire();
      if (v.take) begin
        exp_cause = v.cause; exp_epc = v.pc; exp_stat = 5'h16;
      end
      check(TAGS[i], "redirect", {31'b0, redirect}, {31'b0, v.take});
      check(TAGS[i], "cause", cause, exp_cause);
      check("R6", "epc", epc, exp_epc);
      check("R5", "status", {27'b0, status}, {27'b0, exp_stat});
      @(negedge clk);
      check("R9", "redirect drop", {31'b0, redirect}, 32'h0);
    end

    // R9: request held three cycles -> pulse, discarded, pulse
    cfg_write(2'd2, 32'h0);
    retire_valid = 1'b1; cur_level = 4'd5; retire_pc = 32'h2000; brk_wide = 1'b1;
    @(negedge clk);
    check("R9", "first pulse", {31'b0, redirect}, 32'h1);
    retire_pc = 32'h2004;
    @(negedge clk);
    check("R9", "discarded in redirect cycle", {31'b0, redirect}, 32'h0);
    check("R9", "epc kept", epc, 32'h2000);
    retire_pc = 32'h2008;
    @(negedge clk);
    clear_retire();
    check("R9", "second pulse", {31'b0, redirect}, 32'h1);
    check("R6", "epc second", epc, 32'h2008);
    @(negedge clk);

    // R11 / R7: comparator 1 through its own slot and enable bit 1
    cfg_write(2'd1, 32'h3000);
    cfg_write(2'd2, 32'h2);
    retire_valid = 1'b1; cur_level = 4'd2; retire_pc = 32'h3000;
    @(negedge clk);
    clear_retire();
    check("R11", "slot1 redirect", {31'b0, redirect}, 32'h1);
    check("R11", "slot1 cause", cause, 32'h2);
    @(negedge clk);
    cfg_write(2'd2, 32'h1);
    retire_valid = 1'b1; retire_pc = 32'h3000;
    @(negedge clk);
    clear_retire();
    check("R7", "slot1 disabled", {31'b0, redirect}, 32'h0);
    check("R7", "cause kept", cause, 32'h2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule